// File: doc/BRIEF.md
# Collision Turn Scheduler

This block sits in every node attached to a shared multi-wavelength channel. Several nodes may start an arbitration header on the same slot. Their one-hot source fields then overlap, and the channel shows their OR. Every node sees that OR at the same time. It also sees the same free-running cycle counter, which all nodes align at startup. From these two values each copy of the block works out, on its own, the same fair order in which the colliding senders get the channel. No grant message is exchanged.

The schedule is a run of turns with no gap between them. A turn opens with a short header phase, during which every node listens. The header carries only the destination index and a one-bit size flag. A data phase follows, and its length depends on that size flag. During the data phase the owner sends, the addressed node receives, and every other node detunes. When the last collider has finished, the block reports the channel idle again, and a fresh collision can start a new schedule.

Top module: `turn_sched`

## Requirements
- R1: After reset, `busy_o`=0, `owner_o`=0, `role_o`=IDLE (0) and `err_o`=0.
- R2: A `collide_i` pulse sampled while idle, with two or more bits set in `src_or_i`, starts a schedule. From the next cycle `busy_o`=1. The first owner is the collider n with the smallest key (n + c) mod NODES, where c is `cycle_cnt_i` sampled on that same edge.
- R3: The later owners follow in ascending key order, using the same latched c. Nodes not in the collider set take no cycles.
- R4: Each turn starts with HDR_CYC header cycles. During these, `role_o` is SEND (2) in the owner and LISTEN (1) in every other node. On the last header cycle the block samples `hdr_dest_i` and `hdr_long_i`.
- R5: After the header comes a data phase. It lasts LONG_FLITS cycles when `hdr_long_i`=1 and SHORT_FLITS cycles when it is 0. In this phase `role_o` is SEND (2) in the owner, RECV (3) in the node whose index equals the sampled destination, and IGNORE (4) in every other node. When the owner and the destination are the same node, SEND takes precedence.
- R6: The header of the next owner begins in the cycle right after the last data cycle of the previous owner.
- R7: In the cycle after the last collider's final data cycle, `busy_o`=0 and `role_o`=IDLE. A collision sampled in that cycle starts a new schedule.
- R8: A `collide_i` pulse while `busy_o`=1 is ignored. The running order is unchanged, and `err_o` stays unchanged.
- R9: A `collide_i` pulse while idle, with fewer than two bits set in `src_or_i`, sets `err_o`. The flag stays set until reset, and no schedule starts.
- R10: Copies of the block that differ only in `node_id_i` and receive the same other inputs report the same `owner_o` and `busy_o` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id_i | input | IDX_W | Index of the local node |
| collide_i | input | 1 | One-cycle collision indication |
| src_or_i | input | NODES | OR of the overlapping one-hot source fields |
| cycle_cnt_i | input | CNT_W | Global cycle count, aligned in all nodes |
| hdr_dest_i | input | IDX_W | Destination carried by the short header on the channel |
| hdr_long_i | input | 1 | Size flag of the short header (1 = long packet) |
| busy_o | output | 1 | A collision schedule is in progress |
| owner_o | output | IDX_W | Index of the node that holds the current turn |
| role_o | output | 3 | Local role: 0 idle, 1 listen, 2 send, 3 receive, 4 ignore |
| err_o | output | 1 | Sticky flag for a collision with fewer than two sources |

## Verification
The assertions assume that `collide_i` is a pulse that the caller raises only while the channel shows an aligned collision. They also assume that the header inputs hold the owner's packet on the last header cycle, that `cycle_cnt_i` is identical in every copy, and that NODES does not exceed the range of `cycle_cnt_i`. The bench meets these assumptions by driving one set of inputs to four copies that differ only in their index. It derives the header values from its own model of who owns the turn, and it changes inputs only on the falling edge. It deliberately raises collisions in the middle of a schedule, and also raises collisions that carry only one source, so that the ignore rule and the error rule are both exercised.

// File: rtl/tsched_pkg.sv
package tsched_pkg;

  typedef enum logic [2:0] {
    ROLE_IDLE   = 3'd0,
    ROLE_LISTEN = 3'd1,
    ROLE_SEND   = 3'd2,
    ROLE_RECV   = 3'd3,
    ROLE_IGNORE = 3'd4
  } role_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

endpackage

// File: rtl/tsched_pick.sv
// Rotating first-set finder: returns the member of set_i whose key
// (index + off_i) mod NODES is the smallest.
module tsched_pick #(
  parameter int NODES = 4,
  parameter int IDX_W = 2
) (
  input  logic [NODES-1:0] set_i,
  input  logic [IDX_W-1:0] off_i,
  output logic [IDX_W-1:0] first_o,
  output logic             any_o
);

  logic [IDX_W-1:0] cand;

  always_comb begin
    first_o = '0;
    any_o   = 1'b0;
    cand    = '0;
    // Walk the keys from the highest down, so that the smallest key wins.
    for (int k = NODES - 1; k >= 0; k--) begin
      cand = IDX_W'((k + NODES - int'(off_i)) % NODES);
      if (set_i[cand]) begin
        first_o = cand;
        any_o   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tsched_seq.sv
// Turn sequencer: header phase, then data phase, then the next member of
// the collider set.
module tsched_seq
  import tsched_pkg::*;
#(
  parameter int NODES       = 4,
  parameter int IDX_W       = 2,
  parameter int HDR_CYC     = 1,
  parameter int SHORT_FLITS = 2,
  parameter int LONG_FLITS  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] node_id_i,
  input  logic             start_i,
  input  logic [NODES-1:0] start_set_i,
  input  logic [IDX_W-1:0] start_off_i,
  input  logic [IDX_W-1:0] start_owner_i,
  input  logic [IDX_W-1:0] next_owner_i,
  input  logic [IDX_W-1:0] hdr_dest_i,
  input  logic             hdr_long_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] owner_o,
  output logic [2:0]       role_o,
  output logic [NODES-1:0] rest_o,
  output logic [IDX_W-1:0] off_o
);

  localparam int MAX_FL = (LONG_FLITS > SHORT_FLITS) ? LONG_FLITS : SHORT_FLITS;
  localparam int HC_W   = (HDR_CYC > 1) ? $clog2(HDR_CYC) : 1;
  localparam int DC_W   = (MAX_FL > 1) ? $clog2(MAX_FL) : 1;

  phase_e           phase_q;
  logic [HC_W-1:0]  hcnt_q;
  logic [DC_W-1:0]  dcnt_q;
  logic [NODES-1:0] remain_q;
  logic [IDX_W-1:0] owner_q;
  logic [IDX_W-1:0] off_q;
  role_e            role_q;
  logic             busy_q;

  logic hdr_last;
  logic data_last;

  assign hdr_last  = (phase_q == PH_HDR)  && (hcnt_q == HC_W'(HDR_CYC - 1));
  assign data_last = (phase_q == PH_DATA) && (dcnt_q == '0);
  assign rest_o    = remain_q & ~(NODES'(1) << owner_q);

  assign busy_o  = busy_q;
  assign owner_o = owner_q;
  assign role_o  = role_q;
  assign off_o   = off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      hcnt_q   <= '0;
      dcnt_q   <= '0;
      remain_q <= '0;
      owner_q  <= '0;
      off_q    <= '0;
      role_q   <= ROLE_IDLE;
      busy_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q  <= PH_HDR;
            hcnt_q   <= '0;
            remain_q <= start_set_i;
            off_q    <= start_off_i;
            owner_q  <= start_owner_i;
            busy_q   <= 1'b1;
            role_q   <= (start_owner_i == node_id_i) ? ROLE_SEND : ROLE_LISTEN;
          end
        end
        PH_HDR: begin
          if (hdr_last) begin
            phase_q <= PH_DATA;
            dcnt_q  <= hdr_long_i ? DC_W'(LONG_FLITS - 1) : DC_W'(SHORT_FLITS - 1);
            if (owner_q == node_id_i)      role_q <= ROLE_SEND;
            else if (hdr_dest_i == node_id_i) role_q <= ROLE_RECV;
            else                           role_q <= ROLE_IGNORE;
          end else begin
            hcnt_q <= hcnt_q + HC_W'(1);
          end
        end
        PH_DATA: begin
          if (data_last) begin
            remain_q <= rest_o;
            if (rest_o != '0) begin
              phase_q <= PH_HDR;
              hcnt_q  <= '0;
              owner_q <= next_owner_i;
              role_q  <= (next_owner_i == node_id_i) ? ROLE_SEND : ROLE_LISTEN;
            end else begin
              phase_q <= PH_IDLE;
              owner_q <= '0;
              off_q   <= '0;
              busy_q  <= 1'b0;
              role_q  <= ROLE_IDLE;
            end
          end else begin
            dcnt_q <= dcnt_q - DC_W'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // The collider set only loses members while a schedule runs (R8).
  p_set_shrinks_r8: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ((remain_q & ~$past(remain_q)) == '0));

  // The current owner is always a pending collider (R3).
  p_owner_member_r3: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> remain_q[owner_q]);

  // No idle cycle between two turns (R6).
  p_no_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (data_last && (rest_o != '0)) |=> (phase_q == PH_HDR) && busy_q);

  // The channel is released after the final turn (R7).
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (data_last && (rest_o == '0)) |=> (!busy_q && (role_q == ROLE_IDLE)));

endmodule

// File: rtl/turn_sched.sv
module turn_sched
  import tsched_pkg::*;
#(
  parameter int NODES       = 4,
  parameter int CNT_W       = 8,
  parameter int HDR_CYC     = 1,
  parameter int SHORT_FLITS = 2,
  parameter int LONG_FLITS  = 5,
  parameter int IDX_W       = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] node_id_i,
  input  logic             collide_i,
  input  logic [NODES-1:0] src_or_i,
  input  logic [CNT_W-1:0] cycle_cnt_i,
  input  logic [IDX_W-1:0] hdr_dest_i,
  input  logic             hdr_long_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] owner_o,
  output logic [2:0]       role_o,
  output logic             err_o
);

  localparam int POP_W = IDX_W + 1;

  logic [POP_W-1:0] ones;
  logic             multi;
  logic [CNT_W-1:0] off_wide;
  logic [IDX_W-1:0] start_off;
  logic [IDX_W-1:0] start_owner;
  logic             start_any;
  logic [IDX_W-1:0] next_owner;
  logic             next_any;
  logic [NODES-1:0] rest;
  logic [IDX_W-1:0] off_q;
  logic             start;
  logic             err_q;

  always_comb begin
    ones = '0;
    for (int k = 0; k < NODES; k++) ones = ones + POP_W'(src_or_i[k]);
  end

  assign multi     = (ones >= POP_W'(2));
  assign off_wide  = cycle_cnt_i % CNT_W'(NODES);
  assign start_off = off_wide[IDX_W-1:0];
  assign start     = collide_i && !busy_o && multi && start_any;

  tsched_pick #(.NODES(NODES), .IDX_W(IDX_W)) i_pick_first (
    .set_i   (src_or_i),
    .off_i   (start_off),
    .first_o (start_owner),
    .any_o   (start_any)
  );

  tsched_pick #(.NODES(NODES), .IDX_W(IDX_W)) i_pick_next (
    .set_i   (rest),
    .off_i   (off_q),
    .first_o (next_owner),
    .any_o   (next_any)
  );

  tsched_seq #(
    .NODES(NODES), .IDX_W(IDX_W), .HDR_CYC(HDR_CYC),
    .SHORT_FLITS(SHORT_FLITS), .LONG_FLITS(LONG_FLITS)
  ) i_seq (
    .clk           (clk),
    .rst           (rst),
    .node_id_i     (node_id_i),
    .start_i       (start),
    .start_set_i   (src_or_i),
    .start_off_i   (start_off),
    .start_owner_i (start_owner),
    .next_owner_i  (next_owner),
    .hdr_dest_i    (hdr_dest_i),
    .hdr_long_i    (hdr_long_i),
    .busy_o        (busy_o),
    .owner_o       (owner_o),
    .role_o        (role_o),
    .rest_o        (rest),
    .off_o         (off_q)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else if (collide_i && !busy_o && !multi) err_q <= 1'b1;
  end

  assign err_o = err_q;

  // A valid collision starts a schedule (R2).
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (collide_i && !busy_o && multi) |=> busy_o);

  // A collision with fewer than two sources raises the flag and starts nothing (R9).
  p_single_err_r9: assert property (@(posedge clk) disable iff (rst)
    (collide_i && !busy_o && !multi) |=> (err_o && !busy_o));

  // The error flag is sticky (R9).
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  // A collision while busy leaves the flag unchanged (R8).
  p_busy_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (collide_i && busy_o) |=> (err_o == $past(err_o)));

  // Only the owner sends, and only during a schedule (R5).
  p_send_owner_r5: assert property (@(posedge clk) disable iff (rst)
    (role_o == ROLE_SEND) |-> (busy_o && (owner_o == node_id_i)));

  // While a turn is pending, the next pick always finds a member (R3).
  p_next_found_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && (rest != '0)) |-> next_any);

endmodule

// File: tb/test_turn_sched.sv
module test_turn_sched;

  localparam int NODES = 4;
  localparam int CNT_W = 8;
  localparam int HDR_CYC = 1;
  localparam int SHORT_FLITS = 2;
  localparam int LONG_FLITS = 5;
  localparam int IDX_W = 2;

  // Vector fields: [23:20] collider set, [19:12] cycle count,
  // [11:8] size flag per node, [7:0] destination per node (2 bits each).
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {4'b1100, 8'd5,   4'b0101, 8'b00110001},
    {4'b0011, 8'd0,   4'b0000, 8'b00110001},
    {4'b1111, 8'd2,   4'b1010, 8'b00110001},
    {4'b1011, 8'd7,   4'b1111, 8'b00110001},
    {4'b0110, 8'd255, 4'b0000, 8'b00110001},
    {4'b1101, 8'd3,   4'b1001, 8'b00110001}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic collide = 1'b0;
  logic [NODES-1:0] src_or = '0;
  logic [CNT_W-1:0] cnt = '0;
  logic [IDX_W-1:0] hdr_dest = '0;
  logic hdr_long = 1'b0;

  logic             busy_w  [NODES];
  logic [IDX_W-1:0] owner_w [NODES];
  logic [2:0]       role_w  [NODES];
  logic             err_w   [NODES];

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < NODES; g++) begin : g_node
    turn_sched #(
      .NODES(NODES), .CNT_W(CNT_W), .HDR_CYC(HDR_CYC),
      .SHORT_FLITS(SHORT_FLITS), .LONG_FLITS(LONG_FLITS)
    ) i_turn_sched (
      .clk(clk), .rst(rst), .node_id_i(IDX_W'(g)),
      .collide_i(collide), .src_or_i(src_or), .cycle_cnt_i(cnt),
      .hdr_dest_i(hdr_dest), .hdr_long_i(hdr_long),
      .busy_o(busy_w[g]), .owner_o(owner_w[g]), .role_o(role_w[g]), .err_o(err_w[g])
    );
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R10: all copies agree on owner and busy in this cycle.
  task automatic chk_agree();
    int same;
    same = 1;
    for (int k = 1; k < NODES; k++)
      if (owner_w[k] != owner_w[0] || busy_w[k] != busy_w[0]) same = 0;
    chk("R10 lockstep owner", same, 1);
  endtask

  task automatic chk_idle(input string req, input int exp_err);
    for (int k = 0; k < NODES; k++) begin
      chk({req, " busy"}, int'(busy_w[k]), 0);
      chk({req, " role"}, int'(role_w[k]), 0);
      chk({req, " err"}, int'(err_w[k]), exp_err);
    end
  endtask

  // poke: raise a one-source collision during the first data cycle (R8).
  task automatic run_sched(input logic [23:0] v, input bit poke);
    int order [NODES];
    int n_turns;
    int off;
    int o;
    int len;
    n_turns = 0;
    off = int'(v[19:12]) % NODES;
    for (int key = 0; key < NODES; key++) begin
      int nd;
      nd = (key + NODES - off) % NODES;
      if (v[20 + nd]) begin
        order[n_turns] = nd;
        n_turns++;
      end
    end
    collide = 1'b1;
    src_or = v[23:20];
    cnt = v[19:12];
    @(posedge clk);
    @(negedge clk);
    collide = 1'b0;
    cnt = cnt + 8'd1;
    for (int t = 0; t < n_turns; t++) begin
      o = order[t];
      for (int h = 0; h < HDR_CYC; h++) begin
        chk_agree();
        for (int k = 0; k < NODES; k++) begin
          chk((t == 0) ? "R2 first owner" : "R3 R6 next owner", int'(owner_w[k]), o);
          chk("R2 busy", int'(busy_w[k]), 1);
          chk("R4 header role", int'(role_w[k]), (k == o) ? 2 : 1);
        end
        hdr_dest = v[2*o +: 2];
        hdr_long = v[8 + o];
        @(posedge clk);
        @(negedge clk);
      end
      len = v[8 + o] ? LONG_FLITS : SHORT_FLITS;
      for (int f = 0; f < len; f++) begin
        chk_agree();
        for (int k = 0; k < NODES; k++) begin
          int exp_role;
          if (k == o) exp_role = 2;
          else if (k == int'(v[2*o +: 2])) exp_role = 3;
          else exp_role = 4;
          chk("R5 data role", int'(role_w[k]), exp_role);
          chk("R5 owner held", int'(owner_w[k]), o);
        end
        if (poke && t == 0 && f == 0) begin
          collide = 1'b1;
          src_or = 4'b0100;
          cnt = cnt + 8'd1;
        end
        @(posedge clk);
        @(negedge clk);
        collide = 1'b0;
      end
    end
    chk_agree();
    chk_idle(poke ? "R7 R8 release" : "R7 release", 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NODES; k++) chk("R1 owner", int'(owner_w[k]), 0);
    chk_idle("R1 reset", 0);

    // Table walk: schedules back to back, each begun right after release (R7).
    for (int i = 0; i < NV; i++) run_sched(VEC[i], 1'b0);

    // R8: a collision raised mid-schedule is ignored.
    run_sched({4'b1011, 8'd1, 4'b0100, 8'b00110001}, 1'b1);

    // R9: a single-source collision sets the sticky flag.
    collide = 1'b1;
    src_or = 4'b0100;
    @(posedge clk);
    @(negedge clk);
    collide = 1'b0;
    chk_idle("R9 single source", 1);
    collide = 1'b1;
    src_or = 4'b0000;
    @(posedge clk);
    @(negedge clk);
    collide = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk_idle("R9 sticky", 1);

    // Reset clears the flag (R1).
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_idle("R1 reset clears flag", 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule